// File: doc/BRIEF.md
# Instruction Cache Invalidation and Key Rotation Sequencer

This block sequences a full invalidation of an instruction cache whose line data is held in scrambled form. When an invalidation starts, it sweeps a line index through every tag entry, one per clock, and asserts a tag write enable so that each entry is written invalid. At the same start it raises a request for a fresh scrambling key and keeps it raised until the key source answers with a key-valid acknowledge. The cache is declared usable only once both the sweep and the key handshake have completed, whichever completes later.

Control is a three-state machine: idle, sweeping, and waiting for the key. Reset enters the sweeping state so that the cache comes out of reset empty and with a freshly requested key. A new invalidation request at any time, including the very last cycle of a sweep or while waiting for the key, restarts the whole sweep from index zero and issues a new key request. A new key is therefore never accepted without a complete sweep that starts at or after the request that asked for it.

Top module: `icache_inval_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is sweeping: tag_we_o is 1, tag_idx_o is 0, key_req_o is 1 and busy_o is 1.
- R2: During a sweep with no new request, tag_we_o is 1 and tag_idx_o rises by exactly one per cycle from 0 to NUM_LINES-1, so each line index is presented once.
- R3: key_req_o rises only in the cycle after a start (reset or inval_req_i), stays at 1 until key_valid_i is sampled at 1 while key_req_o is 1, and is 0 from the following cycle.
- R4: key_valid_i sampled while key_req_o is 0 has no effect: outputs keep their values and a later key request still needs its own acknowledge.
- R5: inval_req_i sampled during a sweep, at any index including NUM_LINES-1, makes tag_idx_o 0, key_req_o 1 and busy_o 1 in the next cycle, and any earlier acknowledge is discarded.
- R6: inval_req_i sampled while waiting for the key returns the block to sweeping from index 0 in the next cycle.
- R7: busy_o falls only after the cycle that presents index NUM_LINES-1 and after an acknowledge seen since the latest start; if the acknowledge came first, busy_o falls right after the last index, otherwise right after the acknowledge.
- R8: busy_o is 1 whenever tag_we_o is 1; outside a sweep tag_we_o is 0 and tag_idx_o is 0.
- R9: inval_req_i sampled while idle starts a sweep at index 0 with key_req_o 1 in the next cycle.
- R10: If inval_req_i and key_valid_i are sampled at 1 in the same cycle, the request wins: key_req_o stays 1 and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inval_req_i | input | 1 | Request a full invalidation (sampled each cycle) |
| key_valid_i | input | 1 | Acknowledge from the key source that the new key is valid |
| tag_we_o | output | 1 | Tag write enable, writes the entry at tag_idx_o invalid |
| tag_idx_o | output | $clog2(NUM_LINES) | Line index being invalidated |
| key_req_o | output | 1 | Request for a new scrambling key, held until acknowledged |
| busy_o | output | 1 | Cache unusable; lookups must be blocked while 1 |

## Verification
The hardest situation to reach is a new request landing exactly in the cycle that presents the last line index, after the key has already been acknowledged, since the block would otherwise go idle in the next cycle with a rotated key but an incomplete sweep. The stimulus watches tag_idx_o from the ports, acknowledges the key early in the sweep, and raises the request in the cycle where the index reads NUM_LINES-1. Requests coinciding with acknowledges and requests during the key wait are forced the same way, and a long pseudo-random phase mixes both inputs against a behavioural model compared every cycle.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SWEEP   = 2'd1,
      ST_KEYWAIT = 2'd2
   } icinv_state_e;

   typedef struct packed {
      logic clear;
      logic step;
   } icinv_ctr_cmd_t;

endpackage

// File: rtl/icinv_line_ctr.sv
module icinv_line_ctr #(
   parameter int unsigned NUM_LINES = 64,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  icinv_pkg::icinv_ctr_cmd_t  cmd_i,
   output logic [IDX_W-1:0]           idx_o,
   output logic                       at_last_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);
   localparam bit               IS_POW2  = (NUM_LINES & (NUM_LINES - 1)) == 0;

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q <= '0;
      end else if (cmd_i.clear) begin
         idx_q <= '0;
      end else if (cmd_i.step) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   generate
      if (IS_POW2) begin : g_last_and
         assign at_last_o = &idx_q;
      end else begin : g_last_cmp
         assign at_last_o = (idx_q == LAST_IDX);
      end
   endgenerate

   assign idx_o = idx_q;

   logic live_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   a_r2_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(cmd_i.step) && !$past(cmd_i.clear))
         |-> (idx_o == IDX_W'($past(idx_o) + 1'b1)))
      else $error("idx did not advance by one");

   a_r2_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.step |-> !at_last_o)
      else $error("step requested past last line");

   a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(cmd_i.clear)) |-> (idx_o == '0))
      else $error("clear did not return idx to zero");

endmodule

// File: rtl/icinv_key_track.sv
module icinv_key_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic key_valid_i,
   output logic key_req_o,
   output logic key_ack_o,
   output logic key_done_o
);

   logic req_q;
   logic done_q;

   assign key_ack_o = req_q & key_valid_i & ~start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (start_i) begin
         req_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (key_ack_o) begin
         req_q  <= 1'b0;
         done_q <= 1'b1;
      end
   end

   assign key_req_o  = req_q;
   assign key_done_o = done_q;

   logic live_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(key_req_o) && !$past(key_valid_i)) |-> key_req_o)
      else $error("key request dropped without acknowledge");

   a_r3_rise_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $rose(key_req_o)) |-> $past(start_i))
      else $error("key request rose without a start");

   a_r10_start_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(start_i)) |-> (key_req_o && !key_done_o))
      else $error("start did not re-arm the key request");

endmodule

// File: rtl/icinv_fsm.sv
module icinv_fsm
   import icinv_pkg::*;
(
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           req_i,
   input  logic           at_last_i,
   input  logic           key_ack_i,
   input  logic           key_done_i,
   output icinv_state_e   state_o,
   output icinv_ctr_cmd_t cmd_o
);

   icinv_state_e state_q, state_d;

   always_comb begin
      state_d     = state_q;
      cmd_o.clear = 1'b0;
      cmd_o.step  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i) begin
               state_d     = ST_SWEEP;
               cmd_o.clear = 1'b1;
            end
         end
         ST_SWEEP: begin
            if (req_i) begin
               cmd_o.clear = 1'b1;
            end else if (at_last_i) begin
               cmd_o.clear = 1'b1;
               state_d     = (key_done_i || key_ack_i) ? ST_IDLE : ST_KEYWAIT;
            end else begin
               cmd_o.step = 1'b1;
            end
         end
         ST_KEYWAIT: begin
            if (req_i) begin
               state_d     = ST_SWEEP;
               cmd_o.clear = 1'b1;
            end else if (key_ack_i) begin
               state_d = ST_IDLE;
            end
         end
         default: begin
            state_d     = ST_SWEEP;
            cmd_o.clear = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_SWEEP;
      else         state_q <= state_d;
   end

   assign state_o = state_q;

   logic live_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q <= 1'b0;
      else         live_q <= 1'b1;
   end

   a_r7_idle_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(state_q) != ST_IDLE && state_q == ST_IDLE)
         |-> $past(key_ack_i || key_done_i))
      else $error("went idle without key acknowledge");

   a_r7_idle_needs_sweep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(state_q) == ST_SWEEP && state_q == ST_IDLE)
         |-> ($past(at_last_i) && !$past(req_i)))
      else $error("went idle before the sweep finished");

   a_r6_wait_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(state_q) == ST_KEYWAIT && $past(req_i)) |-> (state_q == ST_SWEEP))
      else $error("request during key wait did not restart");

   a_r9_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(state_q) == ST_IDLE && $past(req_i)) |-> (state_q == ST_SWEEP))
      else $error("request while idle did not start a sweep");

   a_r5_restart_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && $past(req_i)) |-> (state_q == ST_SWEEP))
      else $error("request did not lead to sweeping");

endmodule

// File: rtl/icache_inval_ctrl.sv
module icache_inval_ctrl
   import icinv_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inval_req_i,
   input  logic             key_valid_i,
   output logic             tag_we_o,
   output logic [IDX_W-1:0] tag_idx_o,
   output logic             key_req_o,
   output logic             busy_o
);

   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("NUM_LINES must be at least 2");
      end
   endgenerate

   icinv_state_e   state;
   icinv_ctr_cmd_t ctr_cmd;
   logic           at_last;
   logic           key_ack;
   logic           key_done;

   icinv_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (inval_req_i),
      .at_last_i  (at_last),
      .key_ack_i  (key_ack),
      .key_done_i (key_done),
      .state_o    (state),
      .cmd_o      (ctr_cmd)
   );

   icinv_line_ctr #(
      .NUM_LINES (NUM_LINES)
   ) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (ctr_cmd),
      .idx_o     (tag_idx_o),
      .at_last_o (at_last)
   );

   icinv_key_track u_key (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (inval_req_i),
      .key_valid_i (key_valid_i),
      .key_req_o   (key_req_o),
      .key_ack_o   (key_ack),
      .key_done_o  (key_done)
   );

   assign tag_we_o = (state == ST_SWEEP);
   assign busy_o   = (state != ST_IDLE);

   a_r8_we_idx_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tag_we_o |-> (tag_idx_o == '0))
      else $error("index not parked at zero outside a sweep");

   a_r4_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !key_req_o)
      else $error("key request pending while idle");

endmodule

// File: tb/icache_inval_ctrl_bench.sv
module icache_inval_ctrl_bench;

   localparam int N = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       kv = 1'b0;
   logic       tag_we;
   logic [5:0] tag_idx;
   logic       key_req;
   logic       busy;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   icache_inval_ctrl #(.NUM_LINES(N)) u_icache_inval_ctrl (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .inval_req_i (req),
      .key_valid_i (kv),
      .tag_we_o    (tag_we),
      .tag_idx_o   (tag_idx),
      .key_req_o   (key_req),
      .busy_o      (busy)
   );

   // behavioural reference: 0 idle, 1 sweeping, 2 waiting for key
   int m_st;
   int m_cnt;
   int m_kreq;
   int m_kdone;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 1; m_cnt = 0; m_kreq = 1; m_kdone = 0;
      end else begin
         if (req) begin
            m_st = 1; m_cnt = 0; m_kreq = 1; m_kdone = 0;
         end else begin
            if (m_kreq == 1 && kv) begin
               m_kreq = 0; m_kdone = 1;
               if (m_st == 2) m_st = 0;
            end
            if (m_st == 1) begin
               if (m_cnt == N - 1) begin
                  m_cnt = 0;
                  m_st = (m_kdone == 1) ? 0 : 2;
               end else begin
                  m_cnt = m_cnt + 1;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         chk("R2 tag_we", int'(tag_we), (m_st == 1) ? 1 : 0);
         chk("R2 tag_idx", int'(tag_idx), m_cnt);
         chk("R3 key_req", int'(key_req), m_kreq);
         chk("R7 busy", int'(busy), (m_st != 0) ? 1 : 0);
      end
   end

   task automatic step_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_idx(input int v);
      while (!(tag_we && int'(tag_idx) == v)) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      // R1: reset state
      step_n(3);
      chk("R1 we in reset", int'(tag_we), 1);
      chk("R1 idx in reset", int'(tag_idx), 0);
      chk("R1 key_req in reset", int'(key_req), 1);
      chk("R1 busy in reset", int'(busy), 1);
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R1 idx first cycle", int'(tag_idx), 1);

      // full sweep, key late -> wait state
      @(negedge clk);
      wait_idx(N - 1);
      @(posedge clk); #2;
      chk("R8 we off in key wait", int'(tag_we), 0);
      chk("R8 busy in key wait", int'(busy), 1);
      chk("R8 idx parked", int'(tag_idx), 0);
      step_n(5);
      kv = 1'b1;
      @(negedge clk); kv = 1'b0;
      chk("R7 idle after late ack", int'(busy), 0);
      chk("R3 req dropped", int'(key_req), 0);

      // R4: ack while no request pending
      kv = 1'b1;
      step_n(3);
      kv = 1'b0;
      chk("R4 still idle", int'(busy), 0);
      chk("R4 req still low", int'(key_req), 0);

      // R9: start from idle, key acked early
      req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk("R9 sweeping", int'(tag_we), 1);
      chk("R9 idx zero", int'(tag_idx), 0);
      chk("R9 key req", int'(key_req), 1);
      step_n(4);
      kv = 1'b1;
      @(negedge clk); kv = 1'b0;
      chk("R3 req low after ack", int'(key_req), 0);
      wait_idx(N - 1);
      @(negedge clk);
      chk("R7 idle right after last line", int'(busy), 0);

      // R5: restart mid-sweep
      req = 1'b1;
      @(negedge clk); req = 1'b0;
      wait_idx(20);
      req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk("R5 idx back to zero", int'(tag_idx), 0);
      chk("R5 key_req", int'(key_req), 1);

      // R5: restart in the final cycle after early ack
      step_n(3);
      kv = 1'b1;
      @(negedge clk); kv = 1'b0;
      wait_idx(N - 1);
      req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk("R5 last-cycle restart busy", int'(busy), 1);
      chk("R5 last-cycle restart idx", int'(tag_idx), 0);
      chk("R5 last-cycle restart key_req", int'(key_req), 1);
      wait_idx(N - 1);
      @(negedge clk);
      chk("R7 old ack discarded", int'(busy), 1);

      // R6: restart while waiting for key
      step_n(3);
      req = 1'b1;
      @(negedge clk); req = 1'b0;
      chk("R6 sweeping again", int'(tag_we), 1);
      chk("R6 idx zero", int'(tag_idx), 0);

      // R10: request and ack together
      step_n(2);
      req = 1'b1; kv = 1'b1;
      @(negedge clk); req = 1'b0; kv = 1'b0;
      chk("R10 key_req kept", int'(key_req), 1);
      wait_idx(N - 1);
      @(negedge clk);
      chk("R10 waits for fresh ack", int'(busy), 1);
      kv = 1'b1;
      @(negedge clk); kv = 1'b0;
      chk("R10 idle after fresh ack", int'(busy), 0);

      // pseudo-random mix against the model
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         req  = (lfsr[6:0] == 7'd0);
         kv   = lfsr[9] & lfsr[11];
         @(negedge clk);
      end
      req = 1'b0; kv = 1'b0;
      step_n(2);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule